// File: doc/BRIEF.md
# Word-to-Byte Bus Transfer Splitter

This block sits between a host that always issues 16-bit transfers and a device port that may be either byte-wide or word-wide. The host presents an address, write data and a read/write flag with a valid signal and holds them until the block answers with a one-cycle ready pulse. On the device side the block drives a strobe, an address, a write flag and a 16-bit data path, and waits for an acknowledge before it ends each access. The device reports whether it is word-wide on a width input.

When the device is word-wide, the transfer goes through as a single access on all sixteen lanes. When the device is byte-wide, the block runs two accesses that use only the low eight lanes. The low byte goes first at the even address. The high byte goes second at the odd address, and the block moves it down onto the low lanes for that access. On reads, the block builds the 16-bit result from the two returned bytes and hands it to the host with the ready pulse. The width input is taken once, when the transfer starts.

Top module: `bus_width_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, dev_strobe and req_ready are low. The sequencer rests idle until req_valid is seen.
- R2: If dev_wide is 1 when a transfer starts, exactly one device access is made. It uses the even address (req_addr with bit 0 cleared), and write data passes on lanes 15:0 unchanged.
- R3: If dev_wide is 0 when a transfer starts, exactly two device accesses are made. The first uses the even address (bit 0 = 0). The second uses the same address with bit 0 set.
- R4: In a byte access, lanes 7:0 carry req_wdata[7:0] on the first access and req_wdata[15:8] on the second. Lanes 15:8 are driven to zero.
- R5: A byte-wide read returns the first access's lanes 7:0 in rsp_rdata[7:0] and the second access's lanes 7:0 in rsp_rdata[15:8]. dev_rdata[15:8] has no effect in byte mode. A word-wide read returns dev_rdata[15:0].
- R6: req_ready is a single-cycle pulse. It comes in the cycle after the acknowledge of the last access, never earlier, and rsp_rdata is valid while it is high.
- R7: Once a transfer has started, changes on dev_wide have no effect on it. The access count, addresses and lanes follow the value that was sampled at the start.
- R8: An access that has not been acknowledged keeps dev_strobe, dev_addr and dev_wdata unchanged until dev_ack is seen.
- R9: During every access, dev_write equals the host's req_write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host transfer request, held until req_ready |
| req_ready | output | 1 | One-cycle completion pulse |
| req_addr | input | AW | Host address; bit 0 is ignored |
| req_wdata | input | 16 | Host write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_rdata | output | 16 | Assembled read data, valid with req_ready |
| dev_wide | input | 1 | Device is 16 bits wide when 1 |
| dev_strobe | output | 1 | Device access in progress |
| dev_ack | input | 1 | Device completes the current access |
| dev_addr | output | AW | Device access address |
| dev_write | output | 1 | Device access direction |
| dev_wdata | output | 16 | Device write lanes |
| dev_rdata | input | 16 | Device read lanes |

## Verification
A sequencer that enters the wrong state shows up at the ports within one access. A missing or extra second access changes the count of acknowledged strobes before ready. A wrong phase drives the odd address or the high byte on the first access. A width flag that is not held changes the access count when dev_wide toggles during a transfer. A result that is put together wrongly shows on rsp_rdata in the same cycle as the ready pulse. The device model puts a distinct pattern on the unused upper read lanes so that any leak of those lanes shows at once.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACC_LO = 2'd1,
        ST_ACC_HI = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bws_sequencer.sv
module bws_sequencer
    import bws_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    input  logic          dev_wide,
    input  logic          dev_ack,
    input  logic [DW-1:0] dev_rdata,
    output seq_state_e    state,
    output logic          wide,
    output logic [AW-1:0] base_addr,
    output logic [DW-1:0] wdata,
    output logic          write,
    output logic [DW-1:0] rdata
);

    localparam int HALF = DW / 2;

    typedef struct packed {
        seq_state_e    st;
        logic          wide;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          wr;
        logic [DW-1:0] rdata;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_ACC_LO;
                    seq_d.wide  = dev_wide;
                    seq_d.addr  = req_addr & ~AW'(1);
                    seq_d.wdata = req_wdata;
                    seq_d.wr    = req_write;
                    seq_d.rdata = '0;
                end
            end
            ST_ACC_LO: begin
                if (dev_ack) begin
                    if (seq_q.wide) begin
                        seq_d.rdata = dev_rdata;
                        seq_d.st    = ST_DONE;
                    end else begin
                        seq_d.rdata[HALF-1:0] = dev_rdata[HALF-1:0];
                        seq_d.st              = ST_ACC_HI;
                    end
                end
            end
            ST_ACC_HI: begin
                if (dev_ack) begin
                    seq_d.rdata[DW-1:HALF] = dev_rdata[HALF-1:0];
                    seq_d.st               = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state     = seq_q.st;
    assign wide      = seq_q.wide;
    assign base_addr = seq_q.addr;
    assign wdata     = seq_q.wdata;
    assign write     = seq_q.wr;
    assign rdata     = seq_q.rdata;

    // R7
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st != ST_IDLE && $past(seq_q.st) != ST_IDLE) |-> $stable(seq_q.wide));

    // R2
    wide_no_hi_chk: assert property (@(posedge clk) disable iff (rst)
        seq_q.wide |-> seq_q.st != ST_ACC_HI);

    // R3
    hi_after_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == ST_ACC_HI && $past(seq_q.st) != ST_ACC_HI) |-> $past(seq_q.st) == ST_ACC_LO);

endmodule

// File: rtl/bws_lane_steer.sv
module bws_lane_steer
    import bws_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  seq_state_e    state,
    input  logic          wide,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] wdata,
    input  logic          write,
    output logic          dev_strobe,
    output logic [AW-1:0] dev_addr,
    output logic          dev_write,
    output logic [DW-1:0] dev_wdata
);

    localparam int HALF = DW / 2;

    logic hi_phase;
    logic [HALF-1:0] byte_sel;

    always_comb begin
        hi_phase   = (state == ST_ACC_HI);
        dev_strobe = (state == ST_ACC_LO) || hi_phase;
        dev_addr   = base_addr | AW'(hi_phase);
        dev_write  = dev_strobe & write;
        byte_sel   = hi_phase ? wdata[DW-1:HALF] : wdata[HALF-1:0];
        if (!dev_strobe) begin
            dev_wdata = '0;
        end else if (wide) begin
            dev_wdata = wdata;
        end else begin
            dev_wdata = {{HALF{1'b0}}, byte_sel};
        end
    end

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_write,
    output logic [DW-1:0] rsp_rdata,
    input  logic          dev_wide,
    output logic          dev_strobe,
    input  logic          dev_ack,
    output logic [AW-1:0] dev_addr,
    output logic          dev_write,
    output logic [DW-1:0] dev_wdata,
    input  logic [DW-1:0] dev_rdata
);

    seq_state_e    state;
    logic          wide;
    logic [AW-1:0] base_addr;
    logic [DW-1:0] wdata;
    logic          write;
    logic [DW-1:0] rdata;

    bws_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .dev_wide  (dev_wide),
        .dev_ack   (dev_ack),
        .dev_rdata (dev_rdata),
        .state     (state),
        .wide      (wide),
        .base_addr (base_addr),
        .wdata     (wdata),
        .write     (write),
        .rdata     (rdata)
    );

    bws_lane_steer #(.AW(AW), .DW(DW)) u_steer (
        .state      (state),
        .wide       (wide),
        .base_addr  (base_addr),
        .wdata      (wdata),
        .write      (write),
        .dev_strobe (dev_strobe),
        .dev_addr   (dev_addr),
        .dev_write  (dev_write),
        .dev_wdata  (dev_wdata)
    );

    assign req_ready = (state == ST_DONE);
    assign rsp_rdata = rdata;

    // R1
    ready_excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !dev_strobe);

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R6
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> $past(dev_strobe && dev_ack));

    // R8
    access_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_strobe && !dev_ack) |=> (dev_strobe && $stable(dev_addr) && $stable(dev_wdata)));

    // R3
    odd_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_strobe && dev_addr[0]) |-> $past(dev_strobe));

endmodule

// File: tb/bus_width_splitter_bench.sv
`timescale 1ns/1ps
module bus_width_splitter_bench;

    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_write;
    logic [DW-1:0] rsp_rdata;
    logic          dev_wide;
    logic          dev_strobe;
    logic          dev_ack;
    logic [AW-1:0] dev_addr;
    logic          dev_write;
    logic [DW-1:0] dev_wdata;
    logic [DW-1:0] dev_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit model_wide;

    always #2.5 clk = ~clk;

    bus_width_splitter #(.AW(AW), .DW(DW)) u_bus_width_splitter (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_write  (req_write),
        .rsp_rdata  (rsp_rdata),
        .dev_wide   (dev_wide),
        .dev_strobe (dev_strobe),
        .dev_ack    (dev_ack),
        .dev_addr   (dev_addr),
        .dev_write  (dev_write),
        .dev_wdata  (dev_wdata),
        .dev_rdata  (dev_rdata)
    );

    function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5 ^ a[15:8];
    endfunction

    function automatic logic [15:0] word_at(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'h96} ^ 16'h1234;
    endfunction

    function automatic logic [7:0] junk_at(input logic [AW-1:0] a);
        return ~a[7:0] ^ 8'h5E;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic do_xfer(input logic [AW-1:0] a, input logic [15:0] wd, input bit wr,
                           input bit w16, input int ack_pct, input bit flip);
        logic [AW-1:0] base;
        logic [AW-1:0] exp_a;
        logic [15:0]   exp_w;
        logic [15:0]   exp_r;
        logic [AW-1:0] pend_a;
        logic [15:0]   pend_w;
        bit pend;
        bit done;
        int nacc;
        int spins;
        base = a & ~AW'(1);
        pend = 0;
        done = 0;
        nacc = 0;
        spins = 0;
        @(negedge clk);
        req_addr   = a;
        req_wdata  = wd;
        req_write  = wr;
        dev_wide   = w16;
        model_wide = w16;
        req_valid  = 1'b1;
        dev_ack    = 1'b0;
        while (!done && spins < 400) begin
            @(negedge clk);
            spins++;
            if (flip) dev_wide = 1'($urandom % 2);
            if (req_ready) begin
                done = 1;
                // R6: ready only after all accesses
                check(nacc == (w16 ? 1 : 2), w16 ? "R2" : "R3", "access count at ready",
                      32'(nacc), w16 ? 32'd1 : 32'd2);
                check(!dev_strobe, "R6", "strobe with ready", 32'(dev_strobe), 32'd0);
                if (!wr) begin
                    exp_r = w16 ? word_at(base) : {byte_at(base | AW'(1)), byte_at(base)};
                    check(rsp_rdata == exp_r, "R5", "read data", 32'(rsp_rdata), 32'(exp_r));
                end
                req_valid = 1'b0;
                dev_ack   = 1'b0;
            end else if (dev_strobe) begin
                if (pend) begin
                    check(dev_addr == pend_a && dev_wdata == pend_w, "R8", "held access",
                          32'(dev_addr), 32'(pend_a));
                end
                if (w16) dev_rdata = word_at(dev_addr);
                else     dev_rdata = {junk_at(dev_addr), byte_at(dev_addr)};
                dev_ack = (($urandom % 100) < 32'(ack_pct));
                if (dev_ack) begin
                    nacc++;
                    pend = 0;
                    exp_a = (w16 || nacc == 1) ? base : (base | AW'(1));
                    exp_w = w16 ? wd : {8'h00, (nacc == 1) ? wd[7:0] : wd[15:8]};
                    check(dev_addr == exp_a, w16 ? "R2" : "R3", "access address",
                          32'(dev_addr), 32'(exp_a));
                    check(dev_write == wr, "R9", "write flag", 32'(dev_write), 32'(wr));
                    if (wr) begin
                        check(dev_wdata == exp_w, w16 ? "R2" : "R4", "write lanes",
                              32'(dev_wdata), 32'(exp_w));
                    end
                    check(nacc <= (w16 ? 1 : 2), "R7", "too many accesses",
                          32'(nacc), w16 ? 32'd1 : 32'd2);
                end else begin
                    pend   = 1;
                    pend_a = dev_addr;
                    pend_w = dev_wdata;
                end
            end else begin
                dev_ack = 1'b0;
            end
        end
        check(done, "R6", "ready seen", 32'(done), 32'd1);
        @(negedge clk);
        check(!req_ready, "R6", "ready single pulse", 32'(req_ready), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_addr   = '0;
        req_wdata  = '0;
        req_write  = 1'b0;
        dev_wide   = 1'b0;
        dev_ack    = 1'b0;
        dev_rdata  = '0;
        model_wide = 1'b0;
        repeat (4) @(negedge clk);
        // R1 during reset
        check(!dev_strobe && !req_ready, "R1", "outputs in reset",
              32'({dev_strobe, req_ready}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!dev_strobe && !req_ready, "R1", "outputs after reset",
              32'({dev_strobe, req_ready}), 32'd0);
        repeat (3) @(negedge clk);
        check(!dev_strobe, "R1", "idle without request", 32'(dev_strobe), 32'd0);

        // directed corners
        do_xfer(24'h001234, 16'hBEEF, 1'b0, 1'b1, 100, 1'b0); // R2 word read
        do_xfer(24'h004420, 16'hCAFE, 1'b1, 1'b1, 100, 1'b0); // R2 word write
        do_xfer(24'h000A10, 16'h0000, 1'b0, 1'b0, 100, 1'b0); // R5 byte read
        do_xfer(24'h000A12, 16'hA55A, 1'b1, 1'b0, 100, 1'b0); // R4 byte write
        do_xfer(24'h00FF37, 16'h8001, 1'b1, 1'b0, 100, 1'b0); // R3 odd input address
        do_xfer(24'h0123FF, 16'h0000, 1'b0, 1'b0, 15, 1'b0);  // R8 slow device
        do_xfer(24'h000100, 16'h1357, 1'b1, 1'b0, 40, 1'b1);  // R7 width toggles
        do_xfer(24'h000200, 16'h2468, 1'b0, 1'b1, 40, 1'b1);  // R7 width toggles, word

        for (int i = 0; i < 120; i++) begin
            do_xfer(AW'($urandom), 16'($urandom), 1'($urandom % 2), 1'($urandom % 2),
                    20 + int'($urandom % 81), 1'($urandom % 2));
        end

        finish_run();
    end

endmodule